// File: doc/BRIEF.md
# Interleaved Multi-Queue Packet Byte Feeder

This block keeps a set of independent packet queues on chip and supplies a downstream byte-matching pipeline with one byte per clock. A rotating selector visits the queues in strict turn. Consecutive pipeline slots therefore always hold bytes of different packets, and the datapath never has to wait on the result of the previous cycle. Every byte that leaves carries the index of its queue and flags that mark the first and last byte of its packet. A slot whose queue has nothing ready still leaves, as a bubble with valid low.

Packets arrive over a byte-wide valid/ready write port that names the target queue. Each queue is a circular buffer. A packet becomes readable only once its final byte has been written. When the matcher has decided about a packet early, it can ask for a flush of that queue. The rest of the current packet is discarded and the queue moves on to the next buffered packet. A per-queue ignore flag tells downstream logic that results still in flight for that queue are stale. The flag stays up until the next packet of that queue starts.

Top module: `pkt_feeder`

## Requirements
- R1: While reset is held, rd_valid_o is low, every ignore_o bit is low, and wr_ready_o is high for every queue index.
- R2: rd_queue_o advances by one every clock and wraps from NUM_Q-1 to 0. The first cycle after reset reports queue 0.
- R3: Bytes written to a queue come out on that queue's slots in write order. rd_sop_o is high on a packet's first byte, and rd_eop_o is high on the byte written with wr_last_i high. A one-byte packet has both flags high.
- R4: A packet is not emitted until its last byte has been written. A slot with no readable byte shows rd_valid_o low with rd_sop_o and rd_eop_o low, and still carries its queue index.
- R5: A byte is taken only in a cycle with wr_valid_i and wr_ready_o both high. wr_ready_o is low while the queue named by wr_queue_i holds DEPTH bytes. A refused byte is never emitted.
- R6: A flush of a queue that is partway through a packet discards the remaining bytes of that packet. The next packet of that queue comes out complete, starting with rd_sop_o. The slot of the flushed queue in the flush cycle is a bubble.
- R7: A flush of a queue that has no packet in progress discards no bytes.
- R8: ignore_o[q] goes high in the cycle after a flush of queue q. It stays high until the cycle that queue's next packet-start byte is emitted, and reads low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Target queue can take a byte |
| wr_queue_i | input | QW | Target queue of the write |
| wr_data_i | input | DATA_W | Write byte |
| wr_last_i | input | 1 | Byte is the last of its packet |
| flush_i | input | 1 | Flush request |
| flush_queue_i | input | QW | Queue to flush |
| rd_valid_o | output | 1 | Emitted byte is valid |
| rd_queue_o | output | QW | Queue index of this slot |
| rd_data_o | output | DATA_W | Emitted byte |
| rd_sop_o | output | 1 | First byte of a packet |
| rd_eop_o | output | 1 | Last byte of a packet |
| ignore_o | output | NUM_Q | Per-queue stale-result flag |

## Verification
The bench writes a partial packet and leaves it sitting for several rotations. A design that exposed uncommitted bytes would emit them and trip the scoreboard. It then fills one queue to exactly DEPTH bytes and offers one more byte while the queue is refused. A design that ignores wr_ready_o would emit that extra byte, and one with an off-by-one full test would never drop ready. A flush in the middle of a long packet checks that the leftover bytes vanish and the following packet still starts with a start flag. A flush of an idle queue checks that nothing is dropped. The ignore vector is compared in every cycle, so a flag that clears early or never rises is reported.

// File: rtl/feeder_pkg.sv
`timescale 1ns/1ps
package feeder_pkg;
  // per-queue read state
  typedef enum logic [1:0] {
    QS_IDLE = 2'd0,  // head sits on a packet boundary
    QS_MID  = 2'd1,  // packet partly emitted
    QS_DROP = 2'd2   // discarding rest of a flushed packet
  } qstate_e;
endpackage

// File: rtl/queue_sel.sv
`timescale 1ns/1ps
module queue_sel #(
  parameter int NUM_Q = 8,
  parameter int QW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [QW-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sel_o <= '0;
    else if (sel_o == QW'(NUM_Q - 1)) sel_o <= '0;
    else                              sel_o <= sel_o + 1'b1;
  end
endmodule

// File: rtl/pkt_queue.sv
`timescale 1ns/1ps
module pkt_queue
  import feeder_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  output logic              full_o,
  input  logic              flush_i,
  input  logic              rd_en_i,
  output logic              avail_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sop_o,
  output logic              rd_last_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [DEPTH-1:0]  last_mem;
  logic [PW-1:0]     wr_ptr_q, rd_ptr_q, end_ptr_q;
  qstate_e           state_q, state_d;
  logic              has_pkt, head_last, pop, adv;

  assign full_o    = (wr_ptr_q - rd_ptr_q) == PW'(DEPTH);
  // end_ptr_q is one past the last byte of the newest complete packet
  assign has_pkt   = rd_ptr_q != end_ptr_q;
  assign head_last = last_mem[rd_ptr_q[AW-1:0]];
  assign avail_o   = has_pkt && (state_q != QS_DROP) && !flush_i;
  assign rd_data_o = data_mem[rd_ptr_q[AW-1:0]];
  assign rd_sop_o  = state_q == QS_IDLE;
  assign rd_last_o = head_last;
  assign pop       = rd_en_i && avail_o;
  assign adv       = pop || (state_q == QS_DROP);

  always_comb begin
    state_d = state_q;
    if (state_q == QS_DROP) begin
      if (head_last) state_d = QS_IDLE;
    end else if (flush_i) begin
      if (state_q == QS_MID) state_d = QS_DROP;
    end else if (pop) begin
      state_d = head_last ? QS_IDLE : QS_MID;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      data_mem[wr_ptr_q[AW-1:0]] <= wr_data_i;
      last_mem[wr_ptr_q[AW-1:0]] <= wr_last_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      end_ptr_q <= '0;
      state_q   <= QS_IDLE;
    end else begin
      state_q <= state_d;
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (wr_en_i && wr_last_i) end_ptr_q <= wr_ptr_q + 1'b1;
      if (adv) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/pkt_feeder.sv
`timescale 1ns/1ps
module pkt_feeder #(
  parameter  int NUM_Q  = 8,
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 8,
  localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [QW-1:0]     wr_queue_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  input  logic              flush_i,
  input  logic [QW-1:0]     flush_queue_i,
  output logic              rd_valid_o,
  output logic [QW-1:0]     rd_queue_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o,
  output logic [NUM_Q-1:0]  ignore_o
);
  logic [QW-1:0]     sel;
  logic [NUM_Q-1:0]  full, avail, q_sop, q_last, wr_en, rd_en, fl;
  logic [DATA_W-1:0] q_data [NUM_Q];
  logic              pop;

  queue_sel #(.NUM_Q(NUM_Q), .QW(QW)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_o (sel)
  );

  assign wr_ready_o = (int'(wr_queue_i) < NUM_Q) ? !full[wr_queue_i] : 1'b0;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    assign wr_en[g] = wr_valid_i && wr_ready_o && (wr_queue_i == QW'(g));
    assign fl[g]    = flush_i && (flush_queue_i == QW'(g));
    assign rd_en[g] = sel == QW'(g);

    pkt_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en[g]),
      .wr_data_i(wr_data_i),
      .wr_last_i(wr_last_i),
      .full_o   (full[g]),
      .flush_i  (fl[g]),
      .rd_en_i  (rd_en[g]),
      .avail_o  (avail[g]),
      .rd_data_o(q_data[g]),
      .rd_sop_o (q_sop[g]),
      .rd_last_o(q_last[g])
    );

    // stale until this queue starts its next packet
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ignore_o[g] <= 1'b0;
      else if (fl[g])                            ignore_o[g] <= 1'b1;
      else if (rd_en[g] && avail[g] && q_sop[g]) ignore_o[g] <= 1'b0;
    end
  end

  assign pop = avail[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_queue_o <= QW'(NUM_Q - 1);
      rd_data_o  <= '0;
      rd_sop_o   <= 1'b0;
      rd_eop_o   <= 1'b0;
    end else begin
      rd_valid_o <= pop;
      rd_queue_o <= sel;
      rd_data_o  <= q_data[sel];
      rd_sop_o   <= pop && q_sop[sel];
      rd_eop_o   <= pop && q_last[sel];
    end
  end
endmodule

// File: rtl/feeder_chk.sv
`timescale 1ns/1ps
module feeder_chk #(
  parameter int NUM_Q = 8,
  parameter int QW    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic [QW-1:0]    flush_queue_i,
  input logic             rd_valid_o,
  input logic [QW-1:0]    rd_queue_o,
  input logic             rd_sop_o,
  input logic             rd_eop_o,
  input logic [NUM_Q-1:0] ignore_o
);
  logic          run_q;
  logic [QW-1:0] next_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign next_slot = (rd_queue_o == QW'(NUM_Q - 1)) ? '0 : rd_queue_o + 1'b1;

  p_rotate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
    rd_queue_o == (($past(rd_queue_o) == QW'(NUM_Q - 1)) ? '0 : $past(rd_queue_o) + 1'b1));

  p_bubble_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (!rd_sop_o && !rd_eop_o));

  p_flush_bubble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
    (flush_i && flush_queue_i == next_slot) |=> !rd_valid_o);

  p_ignore_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ignore_o[$past(flush_queue_i)]);

  p_ignore_sop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_sop_o) |-> !ignore_o[rd_queue_o]);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_ign
    p_ignore_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
      $fell(ignore_o[g]) |-> (rd_valid_o && rd_sop_o && rd_queue_o == QW'(g)));
  end
endmodule

bind pkt_feeder feeder_chk #(.NUM_Q(NUM_Q), .QW(QW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .flush_queue_i(flush_queue_i),
  .rd_valid_o   (rd_valid_o),
  .rd_queue_o   (rd_queue_o),
  .rd_sop_o     (rd_sop_o),
  .rd_eop_o     (rd_eop_o),
  .ignore_o     (ignore_o)
);

// File: tb/pkt_feeder_test.sv
`timescale 1ns/1ps
module pkt_feeder_test;
  localparam int NQ = 8;
  localparam int DEPTH = 16;
  localparam int QW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid_i = 1'b0, wr_last_i = 1'b0, flush_i = 1'b0;
  logic [QW-1:0] wr_queue_i = '0, flush_queue_i = '0;
  logic [7:0] wr_data_i = '0;
  logic wr_ready_o, rd_valid_o, rd_sop_o, rd_eop_o;
  logic [QW-1:0] rd_queue_o;
  logic [7:0] rd_data_o;
  logic [NQ-1:0] ignore_o;

  always #2.5 clk = ~clk;

  pkt_feeder #(.NUM_Q(NQ), .DEPTH(DEPTH), .DATA_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_queue_i(wr_queue_i),
    .wr_data_i(wr_data_i), .wr_last_i(wr_last_i),
    .flush_i(flush_i), .flush_queue_i(flush_queue_i),
    .rd_valid_o(rd_valid_o), .rd_queue_o(rd_queue_o), .rd_data_o(rd_data_o),
    .rd_sop_o(rd_sop_o), .rd_eop_o(rd_eop_o), .ignore_o(ignore_o)
  );

  typedef struct packed {logic [7:0] d; logic sop; logic eop;} beat_t;
  beat_t exp_q [NQ][$];
  beat_t e;
  int n_vec = 0, n_bad = 0;
  int seen [NQ];
  logic [NQ-1:0] mid = '0, ign_exp = '0;
  logic mon_on = 1'b0, done = 1'b0;
  int prev_q = NQ - 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard as bytes appear
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk(int'(rd_queue_o) == (prev_q + 1) % NQ, "R2", "slot index", rd_queue_o, (prev_q + 1) % NQ);
      prev_q = rd_queue_o;
      if (rd_valid_o) begin
        if (exp_q[rd_queue_o].size() == 0) begin
          chk(0, "R4", "unexpected byte", rd_data_o, 0);
        end else begin
          e = exp_q[rd_queue_o].pop_front();
          chk(rd_data_o == e.d, "R3", "data", rd_data_o, e.d);
          chk({rd_sop_o, rd_eop_o} == {e.sop, e.eop}, "R3", "sop/eop", {rd_sop_o, rd_eop_o}, {e.sop, e.eop});
        end
        mid[rd_queue_o] = !rd_eop_o;
        seen[rd_queue_o]++;
        if (rd_sop_o) ign_exp[rd_queue_o] = 1'b0;
      end else begin
        chk(!rd_sop_o && !rd_eop_o, "R4", "bubble flags", {rd_sop_o, rd_eop_o}, 0);
      end
      chk(ignore_o == ign_exp, "R8", "ignore vector", ignore_o, ign_exp);
    end
  end

  task automatic put(input int q, input logic [7:0] d, input logic last);
    @(negedge clk);
    wr_queue_i = QW'(q); wr_data_i = d; wr_last_i = last; wr_valid_i = 1'b1;
    #1;
    while (!wr_ready_o) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_valid_i = 1'b0;
  endtask

  task automatic push_exp(input int q, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      beat_t b;
      b.d = 8'(base + i); b.sop = (i == 0); b.eop = (i == len - 1);
      exp_q[q].push_back(b);
    end
  endtask

  task automatic send_pkt(input int q, input int len, input int base);
    for (int i = 0; i < len; i++) put(q, 8'(base + i), i == len - 1);
    push_exp(q, len, base);
  endtask

  task automatic do_flush(input int q);
    @(negedge clk); #2;
    if (mid[q]) begin
      while (exp_q[q].size() > 0) begin
        beat_t b;
        b = exp_q[q].pop_front();
        if (b.eop) break;
      end
      mid[q] = 1'b0;
    end
    flush_i = 1'b1; flush_queue_i = QW'(q);
    @(posedge clk); #1;
    flush_i = 1'b0;
    ign_exp[q] = 1'b1;
  endtask

  task automatic drain();
    repeat (NQ * DEPTH * 2 + 40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int s3;
    for (int q = 0; q < NQ; q++) seen[q] = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rd_valid_o == 1'b0, "R1", "valid in reset", rd_valid_o, 0);
    chk(ignore_o == '0, "R1", "ignore in reset", ignore_o, 0);
    for (int q = 0; q < NQ; q++) begin
      wr_queue_i = QW'(q); #0.2;
      chk(wr_ready_o == 1'b1, "R1", "ready in reset", wr_ready_o, 1);
    end
    rst_n = 1'b1; mon_on = 1'b1;

    // R4: uncommitted bytes stay hidden across several rotations
    for (int i = 0; i < 3; i++) put(2, 8'(8'h20 + i), 1'b0);
    repeat (4 * NQ) @(negedge clk);
    chk(seen[2] == 0, "R4", "partial packet hidden", seen[2], 0);
    put(2, 8'h23, 1'b1);
    push_exp(2, 4, 8'h20);

    // R3: every queue, varied lengths, one-byte packet on queue 0
    for (int q = 0; q < NQ; q++) send_pkt(q, q + 1, 8'h40 + 16 * q);
    send_pkt(1, 5, 8'hA0);
    send_pkt(1, 3, 8'hB0);
    drain();

    // R5: fill queue 5 to exactly DEPTH bytes
    for (int i = 0; i < DEPTH - 1; i++) put(5, 8'(8'h60 + i), 1'b0);
    @(negedge clk); wr_queue_i = 3'd5; #1;
    chk(wr_ready_o == 1'b1, "R5", "ready one below full", wr_ready_o, 1);
    put(5, 8'(8'h60 + DEPTH - 1), 1'b1);
    push_exp(5, DEPTH, 8'h60);
    @(negedge clk);
    wr_queue_i = 3'd5; wr_data_i = 8'hEE; wr_last_i = 1'b1; wr_valid_i = 1'b1; #1;
    chk(wr_ready_o == 1'b0, "R5", "ready when full", wr_ready_o, 0);
    @(posedge clk); #1; wr_valid_i = 1'b0;
    drain();
    chk(exp_q[5].size() == 0, "R5", "queue 5 drained", exp_q[5].size(), 0);

    // R6: flush in the middle of a long packet
    send_pkt(3, 12, 8'h80);
    send_pkt(3, 3, 8'hC0);
    s3 = seen[3];
    while (seen[3] < s3 + 2) @(negedge clk);
    do_flush(3);
    s3 = seen[3];
    @(negedge clk);
    chk(ignore_o[3] == 1'b1, "R8", "ignore set after flush", ignore_o[3], 1);
    drain();
    chk(seen[3] - s3 == 3, "R6", "bytes after flush", seen[3] - s3, 3);
    chk(exp_q[3].size() == 0, "R6", "queue 3 drained", exp_q[3].size(), 0);

    // R7: flush of an idle queue drops nothing
    do_flush(6);
    repeat (3 * NQ) @(negedge clk);
    chk(ignore_o[6] == 1'b1, "R8", "ignore held while idle", ignore_o[6], 1);
    s3 = seen[6];
    send_pkt(6, 4, 8'hD0);
    drain();
    chk(seen[6] - s3 == 4, "R7", "bytes after idle flush", seen[6] - s3, 4);
    chk(ignore_o[6] == 1'b0, "R8", "ignore cleared by sop", ignore_o[6], 0);

    for (int q = 0; q < NQ; q++)
      chk(exp_q[q].size() == 0, "R3", "scoreboard empty", exp_q[q].size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule